// File: doc/BRIEF.md
# Block Password Lock and Access Guard

This block holds the access-control state of a block-organised nonvolatile store: a password of one to three 32-bit words per block, a lock flag per block, a protection mode per block and a sticky hide flag per block. A register front end drives single-cycle strobes to set password words, to feed the unlock port, to write protection settings and to hide blocks. All of these act on the block chosen by `sel_blk`. Another side of the chip presents a block number and a privilege level on `acc_blk` and `acc_super`, and the block answers with combinational read and write permissions for that access.

Passwords and protection settings stand in for nonvolatile storage. They survive `rst_n` and are cleared only by `erase_all`. Lock flags, the unlock history and hide flags are volatile. On reset, every block that has a password comes up locked. Block 0 is special. Its flags are merged into every other block's flags. While block 0 is locked, no other block can be reached and no protection setting can be changed.

Top module: `eelock_guard`

## Requirements
- R1: Password words for a block are accepted only in order: the word index `pw_idx` (0, 1 or 2) must equal the number of words already stored for that block. The password length is therefore 1, 2 or 3 words.
- R2: A password write is refused, stores nothing, and raises `pw_err` for exactly the cycle after the strobe, when any of these holds: its data is 0xFFFFFFFF; its index is already used, skips ahead or equals 3; or the selected block is locked.
- R3: An accepted password word leaves its block unlocked (`unlocked`=1). The block stays unlocked until it is locked or `rst_n` is asserted. After a reset, a block that has a password reads locked.
- R4: A block unlocks when the words written to the unlock port since the last restart are exactly the password words in reverse order, so word 0 is written last and the count matches the length. Any extra or wrong word leaves the block locked until the sequence is restarted.
- R5: Writing 0xFFFFFFFF to the unlock port restarts the sequence and locks the selected block if it has a password. A block with no password always reads `unlocked`=1, and this write has no effect on it.
- R6: `prot_data[1:0]` selects the mode. 00: read always, write only when unlocked. 01: read and write only when a password exists and the block is unlocked. 10: read only when unlocked, never write. 11: read only when a password exists and the block is unlocked, never write. A block with no password counts as unlocked.
- R7: `prot_data[2]` set makes the block unreachable, for both read and write, when `acc_super`=0.
- R8: For every block other than 0, the effective 3-bit protection is the bitwise OR of its own setting and block 0's setting.
- R9: While block 0 is locked, every other block has neither read nor write access, and protection writes to any block are ignored.
- R10: `hide_wr` sets the hide flags given by `hide_mask`. Bit 0 is ignored. A hidden block has no access. Hide flags clear only on `rst_n` and are unaffected by `erase_all`.
- R11: `erase_all` clears every password and protection setting, unlocks every block and restarts the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase_all | input | 1 | Wipe passwords and protection |
| sel_blk | input | BW | Block targeted by configuration strobes |
| pw_wr | input | 1 | Password word write strobe |
| pw_idx | input | 2 | Password word index |
| pw_data | input | 32 | Password word |
| unl_wr | input | 1 | Unlock port write strobe |
| unl_data | input | 32 | Unlock port word |
| prot_wr | input | 1 | Protection write strobe |
| prot_data | input | 3 | {supervisor-only, mode[1:0]} |
| hide_wr | input | 1 | Hide strobe |
| hide_mask | input | NUM_BLK | Blocks to hide |
| acc_blk | input | BW | Block being accessed |
| acc_super | input | 1 | Access is privileged |
| rd_ok | output | 1 | Read permitted for acc_blk |
| wr_ok | output | 1 | Write permitted for acc_blk |
| unlocked | output | 1 | Lock status of sel_blk (1 = unlocked) |
| pw_err | output | 1 | Previous password write refused |

## Verification
The bench walks every protection mode with and without a password, in locked and unlocked states, and with supervisor-only set. A wrong mode decode would show up here as a permission bit flipped in one row. It feeds the unlock port in forward order, in reverse order with a leading stray word, and in reverse order after a restart. A matcher that ignored the word count, or compared in forward order, would unlock where it must not. Block 0 is locked while a protection write is aimed at block 1, which catches a gate that fails to block configuration. A design that let `erase_all` clear hide flags, or kept passwords unlocked across reset, is caught by checks made just after each of those events.

// File: rtl/eelock_pkg.sv
// Shared constants and protection encodings for the block lock guard.
package eelock_pkg;
    localparam int WORD_W = 32;
    localparam int PW_MAX = 3;

    typedef enum logic [1:0] {
        MODE_RW_RO    = 2'b00,
        MODE_PW_ONLY  = 2'b01,
        MODE_RO_NONE  = 2'b10,
        MODE_STRICT   = 2'b11
    } mode_e;
endpackage

// File: rtl/eelock_pw_bank.sv
// Password store: per-block words and word count. Accepts words strictly in
// order, refuses all-ones words and writes to locked blocks.
// Assumes: retention across rst_n (no reset); cleared only by erase_i.
module eelock_pw_bank #(
    parameter int NUM_BLK = 4,
    localparam int BW = $clog2(NUM_BLK)
) (
    input  logic                               clk,
    input  logic                               erase_i,
    input  logic                               wr_i,
    input  logic [BW-1:0]                      blk_i,
    input  logic [1:0]                         idx_i,
    input  logic [eelock_pkg::WORD_W-1:0]      data_i,
    input  logic                               blk_locked_i,
    output logic [NUM_BLK-1:0][1:0]            pw_n_o,
    output logic [eelock_pkg::WORD_W-1:0]      sel_w0_o,
    output logic [eelock_pkg::WORD_W-1:0]      sel_w1_o,
    output logic [eelock_pkg::WORD_W-1:0]      sel_w2_o,
    output logic                               accept_o,
    output logic                               refuse_o
);
    import eelock_pkg::*;

    logic [WORD_W-1:0] words [NUM_BLK][PW_MAX];
    logic              blk_ok;

    // Decide whether the presented word is legal.
    always_comb begin
        blk_ok   = int'(blk_i) < NUM_BLK;
        accept_o = wr_i && blk_ok && (idx_i == pw_n_o[blk_i]) && (idx_i != 2'd3)
                   && !(&data_i) && !blk_locked_i;
        refuse_o = wr_i && !accept_o;
    end

    // Store accepted words and advance the count; wipe on erase.
    always_ff @(posedge clk) begin
        if (erase_i) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                pw_n_o[b] <= 2'd0;
                for (int k = 0; k < PW_MAX; k++) words[b][k] <= '0;
            end
        end else if (accept_o) begin
            words[blk_i][idx_i] <= data_i;
            pw_n_o[blk_i]       <= pw_n_o[blk_i] + 2'd1;
        end
    end

    // Present the selected block's words to the unlock matcher.
    always_comb begin
        sel_w0_o = blk_ok ? words[blk_i][0] : '0;
        sel_w1_o = blk_ok ? words[blk_i][1] : '0;
        sel_w2_o = blk_ok ? words[blk_i][2] : '0;
    end
endmodule

// File: rtl/eelock_unlock_match.sv
// Unlock sequence matcher: keeps the two previous unlock words and a count
// of words since the last restart; flags a hit when the newest word is
// password word 0, the ones before it are words 1 and 2, and the count equals
// the password length.
// Assumes: all-ones is never a password word, so it serves as restart.
module eelock_unlock_match (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          wr_i,
    input  logic [eelock_pkg::WORD_W-1:0] data_i,
    input  logic [1:0]                    pw_n_i,
    input  logic [eelock_pkg::WORD_W-1:0] pw0_i,
    input  logic [eelock_pkg::WORD_W-1:0] pw1_i,
    input  logic [eelock_pkg::WORD_W-1:0] pw2_i,
    output logic                          hit_o,
    output logic                          restart_o
);
    import eelock_pkg::*;

    logic [WORD_W-1:0] hist0, hist1;
    logic [2:0]        cnt;

    // Compare the incoming word plus history against the reversed password.
    always_comb begin
        restart_o = wr_i && (&data_i);
        hit_o = wr_i && !(&data_i) && (pw_n_i != 2'd0)
                && ({1'b0, pw_n_i} == cnt + 3'd1)
                && (data_i == pw0_i)
                && ((pw_n_i < 2'd2) || (hist0 == pw1_i))
                && ((pw_n_i < 2'd3) || (hist1 == pw2_i));
    end

    // Shift history and count words; clear on restart, hit, erase or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || restart_o || hit_o) begin
            hist0 <= '0;
            hist1 <= '0;
            cnt   <= 3'd0;
        end else if (wr_i) begin
            hist1 <= hist0;
            hist0 <= data_i;
            cnt   <= (cnt == 3'd4) ? 3'd4 : cnt + 3'd1;
        end
    end
endmodule

// File: rtl/eelock_access_eval.sv
// Access evaluator: merges block 0 flags into the target's flags, applies
// the hide, global-gate and supervisor checks, then decodes the mode.
// Assumes: purely combinational; acc_blk beyond NUM_BLK gets no access.
module eelock_access_eval #(
    parameter int NUM_BLK = 4,
    localparam int BW = $clog2(NUM_BLK)
) (
    input  logic [BW-1:0]            acc_blk_i,
    input  logic                     acc_super_i,
    input  logic [NUM_BLK-1:0][2:0]  prot_i,
    input  logic [NUM_BLK-1:0][1:0]  pw_n_i,
    input  logic [NUM_BLK-1:0]       locked_i,
    input  logic [NUM_BLK-1:0]       hidden_i,
    output logic                     rd_ok_o,
    output logic                     wr_ok_o
);
    import eelock_pkg::*;

    logic [2:0] eff;
    logic       in_rng, gated, unl, own, rd, wr;

    // Derive effective flags and the resulting permissions.
    always_comb begin
        in_rng = int'(acc_blk_i) < NUM_BLK;
        eff    = prot_i[acc_blk_i] | ((acc_blk_i != '0) ? prot_i[0] : 3'b000);
        unl    = !locked_i[acc_blk_i];
        own    = (pw_n_i[acc_blk_i] != 2'd0) && unl;
        gated  = !in_rng || hidden_i[acc_blk_i]
                 || ((acc_blk_i != '0) && locked_i[0])
                 || (eff[2] && !acc_super_i);
        case (mode_e'(eff[1:0]))
            MODE_RW_RO:   begin rd = 1'b1; wr = unl;  end
            MODE_PW_ONLY: begin rd = own;  wr = own;  end
            MODE_RO_NONE: begin rd = unl;  wr = 1'b0; end
            default:      begin rd = own;  wr = 1'b0; end
        endcase
        rd_ok_o = !gated && rd;
        wr_ok_o = !gated && wr;
    end
endmodule

// File: rtl/eelock_guard.sv
// Top: per-block lock, protection and hide state, wired to the password
// bank, unlock matcher and access evaluator.
// Assumes: one configuration strobe acts on sel_blk per cycle; protection
// settings are retained across rst_n and cleared by erase_all.
module eelock_guard #(
    parameter int NUM_BLK = 4,
    localparam int BW = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               erase_all,
    input  logic [BW-1:0]      sel_blk,
    input  logic               pw_wr,
    input  logic [1:0]         pw_idx,
    input  logic [31:0]        pw_data,
    input  logic               unl_wr,
    input  logic [31:0]        unl_data,
    input  logic               prot_wr,
    input  logic [2:0]         prot_data,
    input  logic               hide_wr,
    input  logic [NUM_BLK-1:0] hide_mask,
    input  logic [BW-1:0]      acc_blk,
    input  logic               acc_super,
    output logic               rd_ok,
    output logic               wr_ok,
    output logic               unlocked,
    output logic               pw_err
);
    logic [NUM_BLK-1:0][1:0] pw_n;
    logic [NUM_BLK-1:0][2:0] prot_q;
    logic [NUM_BLK-1:0]      locked_q;
    logic [NUM_BLK-1:0]      hide_q;
    logic [31:0]             w0, w1, w2;
    logic                    pw_accept, pw_refuse, unl_hit, unl_restart, sel_ok;

    assign sel_ok = int'(sel_blk) < NUM_BLK;

    eelock_pw_bank #(.NUM_BLK(NUM_BLK)) u_bank (
        .clk(clk), .erase_i(erase_all), .wr_i(pw_wr), .blk_i(sel_blk),
        .idx_i(pw_idx), .data_i(pw_data), .blk_locked_i(locked_q[sel_blk]),
        .pw_n_o(pw_n), .sel_w0_o(w0), .sel_w1_o(w1), .sel_w2_o(w2),
        .accept_o(pw_accept), .refuse_o(pw_refuse)
    );

    eelock_unlock_match u_match (
        .clk(clk), .rst_n(rst_n), .clr_i(erase_all), .wr_i(unl_wr && sel_ok),
        .data_i(unl_data), .pw_n_i(pw_n[sel_blk]), .pw0_i(w0), .pw1_i(w1),
        .pw2_i(w2), .hit_o(unl_hit), .restart_o(unl_restart)
    );

    eelock_access_eval #(.NUM_BLK(NUM_BLK)) u_eval (
        .acc_blk_i(acc_blk), .acc_super_i(acc_super), .prot_i(prot_q),
        .pw_n_i(pw_n), .locked_i(locked_q), .hidden_i(hide_q),
        .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
    );

    // Lock flags: relock password blocks on reset, unlock on set or match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLK; b++) locked_q[b] <= (pw_n[b] != 2'd0);
        end else if (erase_all) begin
            locked_q <= '0;
        end else begin
            if (pw_accept || unl_hit) locked_q[sel_blk] <= 1'b0;
            if (unl_restart && (pw_n[sel_blk] != 2'd0)) locked_q[sel_blk] <= 1'b1;
        end
    end

    // Protection settings: retained storage, frozen while block 0 is locked.
    always_ff @(posedge clk) begin
        if (erase_all) prot_q <= '0;
        else if (prot_wr && sel_ok && !locked_q[0]) prot_q[sel_blk] <= prot_data;
    end

    // Hide flags: set-only, block 0 excluded, cleared by reset alone.
    always_ff @(posedge clk) begin
        if (!rst_n)       hide_q <= '0;
        else if (hide_wr) hide_q <= hide_q | (hide_mask & ~NUM_BLK'(1));
    end

    // Refusal flag: one-cycle pulse after a rejected password write.
    always_ff @(posedge clk) begin
        if (!rst_n) pw_err <= 1'b0;
        else        pw_err <= pw_refuse;
    end

    assign unlocked = sel_ok && !locked_q[sel_blk];
endmodule

// File: rtl/eelock_guard_chk.sv
// Checker for eelock_guard: protocol properties over ports and state.
module eelock_guard_chk #(
    parameter int NUM_BLK = 4,
    localparam int BW = $clog2(NUM_BLK)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    erase_all,
    input logic [BW-1:0]           sel_blk,
    input logic                    pw_wr,
    input logic [31:0]             pw_data,
    input logic                    unl_wr,
    input logic [31:0]             unl_data,
    input logic [BW-1:0]           acc_blk,
    input logic                    acc_super,
    input logic                    rd_ok,
    input logic                    wr_ok,
    input logic                    unlocked,
    input logic                    pw_err,
    input logic [NUM_BLK-1:0]      locked_q,
    input logic [NUM_BLK-1:0]      hide_q,
    input logic [NUM_BLK-1:0][2:0] prot_q,
    input logic [NUM_BLK-1:0][1:0] pw_n
);
    logic [BW-1:0] sel_d;

    // Remember last cycle's selected block.
    always_ff @(posedge clk) sel_d <= sel_blk;

    AST_PW_ONES_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_wr && (&pw_data)) |=> pw_err);  // R2
    AST_NOPW_READS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_n[sel_blk] == 2'd0) |-> unlocked);  // R5
    AST_ONES_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && (&unl_data) && !erase_all && (pw_n[sel_blk] != 2'd0)) |=> locked_q[sel_d]);  // R5
    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);  // R6
    AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q[acc_blk][2] && !acc_super) |-> (!rd_ok && !wr_ok));  // R7
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_blk != '0) && locked_q[0]) |-> (!rd_ok && !wr_ok));  // R9
    AST_HIDDEN_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        hide_q[acc_blk] |-> (!rd_ok && !wr_ok));  // R10
    AST_HIDE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((hide_q & $past(hide_q)) == $past(hide_q)));  // R10
    AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> unlocked);  // R11
endmodule

bind eelock_guard eelock_guard_chk #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .sel_blk(sel_blk),
    .pw_wr(pw_wr), .pw_data(pw_data), .unl_wr(unl_wr), .unl_data(unl_data),
    .acc_blk(acc_blk), .acc_super(acc_super), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .unlocked(unlocked), .pw_err(pw_err), .locked_q(locked_q), .hide_q(hide_q),
    .prot_q(prot_q), .pw_n(pw_n)
);

// File: tb/tb_eelock_guard.sv
module tb_eelock_guard;
    localparam int NB = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    // {prot[2:0], use_pw, do_lock, super, exp_rd, exp_wr}
    localparam logic [7:0] VEC [12] = '{
        8'b000_0_0_0_1_1, 8'b000_1_0_0_1_1, 8'b000_1_1_0_1_0,
        8'b001_0_0_0_0_0, 8'b001_1_0_0_1_1, 8'b001_1_1_0_0_0,
        8'b010_0_0_0_1_0, 8'b010_1_1_0_0_0, 8'b011_1_0_0_1_0,
        8'b011_0_0_0_0_0, 8'b100_0_0_0_0_0, 8'b100_0_0_1_1_1
    };

    logic clk = 0, rst_n = 0, erase_all = 1;
    logic [1:0] sel_blk = 0, acc_blk = 0, pw_idx = 0;
    logic pw_wr = 0, unl_wr = 0, prot_wr = 0, hide_wr = 0, acc_super = 0;
    logic [31:0] pw_data = 0, unl_data = 0;
    logic [2:0] prot_data = 0;
    logic [NB-1:0] hide_mask = 0;
    logic rd_ok, wr_ok, unlocked, pw_err;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eelock_guard #(.NUM_BLK(NB)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic erase;
        erase_all = 1; step(); erase_all = 0;
    endtask

    task automatic do_reset;
        rst_n = 0; step(); step(); rst_n = 1;
    endtask

    task automatic pw(input logic [1:0] b, input logic [1:0] i, input logic [31:0] d);
        sel_blk = b; pw_idx = i; pw_data = d; pw_wr = 1; step(); pw_wr = 0;
    endtask

    task automatic unl(input logic [1:0] b, input logic [31:0] d);
        sel_blk = b; unl_data = d; unl_wr = 1; step(); unl_wr = 0;
    endtask

    task automatic prot(input logic [1:0] b, input logic [2:0] p);
        sel_blk = b; prot_data = p; prot_wr = 1; step(); prot_wr = 0;
    endtask

    task automatic acc(input string req, input logic [1:0] b, input logic s,
                       input logic er, input logic ew);
        acc_blk = b; acc_super = s; #1;
        chk(req, {30'd0, rd_ok, wr_ok}, {30'd0, er, ew});
    endtask

    task automatic stat(input string req, input logic [1:0] b, input logic e);
        sel_blk = b; #1; chk(req, {31'd0, unlocked}, {31'd0, e});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1; erase_all = 0;
        // Reset state (R11, R3)
        stat("R11 reset unlocked", 2, 1);
        chk("R2 reset pw_err", {31'd0, pw_err}, 32'd0);
        acc("R11 reset access", 2, 0, 1, 1);

        // Mode table (R6, R7)
        for (int i = 0; i < 12; i++) begin
            erase();
            prot(1, VEC[i][7:5]);
            if (VEC[i][4]) pw(1, 0, 32'h1111_0000 + i);
            if (VEC[i][3]) unl(1, ONES);
            acc((VEC[i][7]) ? "R7 supervisor row" : "R6 mode row", 1, VEC[i][2],
                VEC[i][1], VEC[i][0]);
        end

        erase();
        // Password set ordering and refusal (R1, R2, R3)
        pw(2, 1, 32'hB);     chk("R1 out of order refused", {31'd0, pw_err}, 32'd1);
        pw(2, 0, ONES);      chk("R2 ones refused", {31'd0, pw_err}, 32'd1);
        pw(2, 0, 32'hA);     chk("R1 word0 ok", {31'd0, pw_err}, 32'd0);
        pw(2, 1, 32'hB);     chk("R1 word1 ok", {31'd0, pw_err}, 32'd0);
        pw(2, 2, 32'hC);     chk("R1 word2 ok", {31'd0, pw_err}, 32'd0);
        pw(2, 0, 32'hD);     chk("R2 reset word refused", {31'd0, pw_err}, 32'd1);
        step();              chk("R2 err one cycle", {31'd0, pw_err}, 32'd0);
        stat("R3 unlocked after set", 2, 1);

        // Locking and reverse-order unlock (R4, R5)
        unl(2, ONES);        stat("R5 ones locks", 2, 0);
        unl(2, 32'hC); unl(2, 32'hB); stat("R4 partial stays locked", 2, 0);
        unl(2, 32'hA);       stat("R4 reverse unlocks", 2, 1);
        unl(2, ONES); unl(2, 32'hA); unl(2, 32'hB); unl(2, 32'hC);
        stat("R4 forward order stays locked", 2, 0);
        unl(2, ONES); unl(2, 32'h5); unl(2, 32'hC); unl(2, 32'hB); unl(2, 32'hA);
        stat("R4 extra word stays locked", 2, 0);
        unl(2, ONES); unl(2, 32'hC); unl(2, 32'hB); unl(2, 32'hA);
        stat("R4 restart then reverse unlocks", 2, 1);

        // Reset relocks; locked block refuses words (R3, R2)
        pw(3, 0, 32'h33);
        do_reset();
        stat("R3 relocked after reset", 3, 0);
        stat("R3 blk2 relocked after reset", 2, 0);
        pw(3, 1, 32'h44);    chk("R2 locked refuses", {31'd0, pw_err}, 32'd1);
        unl(3, ONES); unl(3, 32'h33); stat("R4 one-word unlock", 3, 1);
        unl(1, ONES);        stat("R5 no password stays open", 1, 1);

        // Block 0 flags merged (R8)
        prot(0, 3'b010); prot(1, 3'b000);
        acc("R8 merged read-only", 1, 0, 1, 0);
        acc("R8 block0 own mode", 0, 0, 1, 0);
        prot(0, 3'b000);

        // Block 0 as global gate (R9)
        pw(0, 0, 32'h55); unl(0, ONES);
        acc("R9 gated while blk0 locked", 1, 0, 0, 0);
        acc("R9 blk0 itself read-only", 0, 0, 1, 0);
        prot(1, 3'b010);
        unl(0, 32'h55);
        acc("R9 prot write ignored", 1, 0, 1, 1);

        // Hide (R10)
        sel_blk = 0; hide_mask = 4'b0011; hide_wr = 1; step(); hide_wr = 0;
        acc("R10 bit0 ignored", 0, 0, 1, 1);
        acc("R10 hidden", 1, 1, 0, 0);
        erase();
        acc("R10 hide survives erase", 1, 1, 0, 0);
        stat("R11 erase unlocks", 2, 1);
        acc("R11 erase opens", 2, 0, 1, 1);
        do_reset();
        acc("R10 reset clears hide", 1, 0, 1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule